// File: doc/BRIEF.md
# Single-Cycle Integer Processor Core

This block is a 32-bit processor core that finishes every instruction in one clock. The program counter selects a word in an internal instruction store, and a combinational controller decodes the opcode and function fields. The datapath then reads two registers, runs the ALU, optionally touches an internal data store, and writes the result back, all within the same cycle. The ALU zero flag goes back to the controller, which uses it to resolve conditional branches. The core executes nine instructions: register add, subtract, AND, OR and signed set-less-than; word load and store; branch-if-equal; and unconditional jump.

While reset is held, a load port fills either the instruction store or the data store one word at a time. After reset is released, the core runs from byte address 0. Each executed instruction is shown on a registered trace. The trace carries the program counter, the register write-back (valid, index, value) and the store (valid, byte address, data). The surrounding logic or a bench compares this trace against an instruction-level model.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a clock edge, `pc_q` becomes 0, `rf_we_q` and `st_q` become 0, and neither the register file nor the data store is written by execution.
- R2: Register operations use opcode 0x00 and are selected by the low 6 bits of the instruction: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR. The result of rs (bits 25:21) with rt (bits 20:16) is written to rd (bits 15:11).
- R3: Function 0x2A writes 1 to rd when rs is less than rt as signed 32-bit values, and 0 otherwise.
- R4: Register 0 always reads as zero. A write that targets it still shows on the trace but leaves it unchanged.
- R5: Load (opcode 0x23) and store (opcode 0x2B) form a byte address from rs plus the sign-extended 16-bit field (bits 15:0). The data store is indexed by address bits [MEM_AW+1:2]. A load writes register rt; a store writes rt to the store and raises `st_q` with that address and data.
- R6: Branch-if-equal (opcode 0x04) sets the next PC to PC+4 plus the sign-extended offset shifted left by 2 when rs equals rt (ALU zero flag), and to PC+4 otherwise.
- R7: Jump (opcode 0x02) sets the next PC to bits 31:28 of PC+4, then the 26-bit target, then two zero bits.
- R8: Every other instruction advances the PC by 4. An unrecognised opcode writes nothing.
- R9: With `ld_we` high, `ld_data` is written to word `ld_addr` of the data store when `ld_dmem` is 1, and of the instruction store otherwise. Stored words are later fetched or loaded unchanged.
- R10: Each clock after reset executes exactly one instruction. Its trace fields and the new `pc_q` appear together after that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; holds execution |
| ld_we | input | 1 | Load port write strobe |
| ld_dmem | input | 1 | Load port target: 1 data store, 0 instruction store |
| ld_addr | input | MEM_AW | Load port word index |
| ld_data | input | DW | Load port write data |
| pc_q | output | DW | Program counter (byte address) |
| rf_we_q | output | 1 | Last instruction wrote a register |
| rf_waddr_q | output | RAW | Register index written |
| rf_wdata_q | output | DW | Value written |
| st_q | output | 1 | Last instruction stored to memory |
| st_addr_q | output | DW | Store byte address |
| st_data_q | output | DW | Store data |

## Verification
Assertions check on every cycle that the PC stays word aligned and steps by 4 after non-control instructions. They also check that taken branches and jumps land on their computed targets, that at most one kind of state update is decoded per cycle, and that a register written in one cycle reads back its new value in the next. The bench alone can show the arithmetic results and signed comparison, the effect of writes to register 0, and load/store addressing with negative offsets. It also checks the not-taken branch path and that an unknown opcode changes no state. It does this by running a program against an instruction-level model and comparing the trace every clock.

// File: rtl/sc_pkg.sv
package sc_pkg;

  localparam int INSN_W = 32;
  localparam int IMM_W  = 16;
  localparam int TGT_W  = 26;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_JUMP  = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic    reg_we;
    logic    dst_rd;
    logic    use_imm;
    logic    mem_to_reg;
    logic    mem_we;
    logic    branch;
    logic    jump;
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/sc_ram.sv
module sc_ram #(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  input  logic       alu_zero,
  output ctrl_t      ctrl,
  output logic       take_br
);
  always_comb begin
    ctrl = '0;
    ctrl.alu_op = ALU_ADD;
    unique case (opcode)
      OP_RTYPE: begin
        ctrl.dst_rd = 1'b1;
        unique case (funct)
          FN_ADD: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_ADD; end
          FN_SUB: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SUB; end
          FN_AND: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_AND; end
          FN_OR:  begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_OR;  end
          FN_SLT: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SLT; end
          default: ctrl.reg_we = 1'b0;
        endcase
      end
      OP_LOAD: begin
        ctrl.reg_we     = 1'b1;
        ctrl.use_imm    = 1'b1;
        ctrl.mem_to_reg = 1'b1;
      end
      OP_STORE: begin
        ctrl.use_imm = 1'b1;
        ctrl.mem_we  = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = ALU_SUB;
      end
      OP_JUMP: ctrl.jump = 1'b1;
      default: ctrl = ctrl;
    endcase
    take_br = ctrl.branch & alu_zero;
  end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  alu_op_e       op,
  output logic [DW-1:0] y,
  output logic          zero
);
  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(DW-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int DW  = 32,
  parameter int RAW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [RAW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [RAW-1:0] raddr_a,
  input  logic [RAW-1:0] raddr_b,
  output logic [DW-1:0]  rdata_a,
  output logic [DW-1:0]  rdata_b
);
  localparam int NREG = 1 << RAW;

  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) regs[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];

  // R4: a register written in one cycle reads its new value in the next
  p_wr_then_rd_r4: assert property (@(posedge clk) disable iff (rst)
    (we && waddr != '0) |=> ((raddr_a != $past(waddr)) || (rdata_a == $past(wdata))));
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int DW     = 32,
  parameter int MEM_AW = 6,
  parameter int RAW    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_we,
  input  logic              ld_dmem,
  input  logic [MEM_AW-1:0] ld_addr,
  input  logic [DW-1:0]     ld_data,
  output logic [DW-1:0]     pc_q,
  output logic              rf_we_q,
  output logic [RAW-1:0]    rf_waddr_q,
  output logic [DW-1:0]     rf_wdata_q,
  output logic              st_q,
  output logic [DW-1:0]     st_addr_q,
  output logic [DW-1:0]     st_data_q
);
  localparam int WIDX_LO = 2;
  localparam int WIDX_HI = MEM_AW + 1;

  logic [INSN_W-1:0] insn;
  logic [5:0]        opcode, funct;
  logic [RAW-1:0]    rs, rt, rd;
  logic [DW-1:0]     simm, rs_val, rt_val, alu_b, alu_y, dm_rdata, wb_val;
  logic [DW-1:0]     pc4, br_tgt, j_tgt, pc_next;
  logic              alu_zero, take_br, rf_we, dm_we;
  logic [RAW-1:0]    wb_idx;
  logic [MEM_AW-1:0] dm_waddr;
  logic [DW-1:0]     dm_wdata;
  ctrl_t             c;
  logic              unused_bits;

  // instruction fetch
  sc_ram #(.DW(DW), .AW(MEM_AW)) u_imem (
    .clk   (clk),
    .we    (ld_we && !ld_dmem),
    .waddr (ld_addr),
    .wdata (ld_data),
    .raddr (pc_q[WIDX_HI:WIDX_LO]),
    .rdata (insn)
  );

  assign opcode = insn[31:26];
  assign rs     = insn[25:21];
  assign rt     = insn[20:16];
  assign rd     = insn[15:11];
  assign funct  = insn[5:0];
  assign simm   = {{(DW-IMM_W){insn[IMM_W-1]}}, insn[IMM_W-1:0]};

  sc_ctrl u_ctrl (
    .opcode   (opcode),
    .funct    (funct),
    .alu_zero (alu_zero),
    .ctrl     (c),
    .take_br  (take_br)
  );

  assign wb_idx = c.dst_rd ? rd : rt;
  assign rf_we  = c.reg_we && !rst;

  sc_regfile #(.DW(DW), .RAW(RAW)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .we      (rf_we),
    .waddr   (wb_idx),
    .wdata   (wb_val),
    .raddr_a (rs),
    .raddr_b (rt),
    .rdata_a (rs_val),
    .rdata_b (rt_val)
  );

  assign alu_b = c.use_imm ? simm : rt_val;

  sc_alu #(.DW(DW)) u_alu (
    .a    (rs_val),
    .b    (alu_b),
    .op   (c.alu_op),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data store: the load port has priority over execution
  assign dm_we    = (ld_we && ld_dmem) || (c.mem_we && !rst);
  assign dm_waddr = (ld_we && ld_dmem) ? ld_addr : alu_y[WIDX_HI:WIDX_LO];
  assign dm_wdata = (ld_we && ld_dmem) ? ld_data : rt_val;

  sc_ram #(.DW(DW), .AW(MEM_AW)) u_dmem (
    .clk   (clk),
    .we    (dm_we),
    .waddr (dm_waddr),
    .wdata (dm_wdata),
    .raddr (alu_y[WIDX_HI:WIDX_LO]),
    .rdata (dm_rdata)
  );

  assign wb_val = c.mem_to_reg ? dm_rdata : alu_y;

  // next PC
  assign pc4    = pc_q + DW'(4);
  assign br_tgt = pc4 + {simm[DW-3:0], 2'b00};
  assign j_tgt  = {pc4[DW-1:DW-4], insn[TGT_W-1:0], 2'b00};

  always_comb begin
    if (c.jump)       pc_next = j_tgt;
    else if (take_br) pc_next = br_tgt;
    else              pc_next = pc4;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q       <= '0;
      rf_we_q    <= 1'b0;
      rf_waddr_q <= '0;
      rf_wdata_q <= '0;
      st_q       <= 1'b0;
      st_addr_q  <= '0;
      st_data_q  <= '0;
    end else begin
      pc_q       <= pc_next;
      rf_we_q    <= c.reg_we;
      rf_waddr_q <= wb_idx;
      rf_wdata_q <= wb_val;
      st_q       <= c.mem_we;
      st_addr_q  <= alu_y;
      st_data_q  <= rt_val;
    end
  end

  assign unused_bits = ^{insn[10:6], pc_q[1:0], alu_y[DW-1:WIDX_HI+1], alu_y[1:0]};

  // R8: the PC never leaves word alignment
  p_pc_word_r8: assert property (@(posedge clk) disable iff (rst)
    pc_q[1:0] == 2'b00);

  // R8: non-control instructions step the PC by one word
  p_seq_pc_r8: assert property (@(posedge clk) disable iff (rst)
    (!c.branch && !c.jump) |=> (pc_q == $past(pc_q) + DW'(4)));

  // R6: a taken branch lands on its computed target
  p_beq_tgt_r6: assert property (@(posedge clk) disable iff (rst)
    take_br |=> (pc_q == $past(br_tgt)));

  // R7: a jump lands on its computed target
  p_jump_tgt_r7: assert property (@(posedge clk) disable iff (rst)
    c.jump |=> (pc_q == $past(j_tgt)));

  // R8: at most one kind of state update is decoded per instruction
  p_ctrl_excl_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({c.reg_we, c.mem_we, c.branch, c.jump}));

  // R1: trace is quiet the cycle after a reset edge
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!rf_we_q && !st_q && pc_q == '0));
endmodule

// File: tb/sc_core_bench.sv
`timescale 1ns/1ps
module sc_core_bench;
  localparam int DW = 32;
  localparam int AW = 6;
  localparam int RAW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_we = 1'b0, ld_dmem = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic [DW-1:0] pc_q, rf_wdata_q, st_addr_q, st_data_q;
  logic [RAW-1:0] rf_waddr_q;
  logic rf_we_q, st_q;

  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  sc_core #(.DW(DW), .MEM_AW(AW), .RAW(RAW)) u_sc_core (
    .clk, .rst, .ld_we, .ld_dmem, .ld_addr, .ld_data,
    .pc_q, .rf_we_q, .rf_waddr_q, .rf_wdata_q, .st_q, .st_addr_q, .st_data_q
  );

  // reference model state
  logic [31:0] m_im [64];
  logic [31:0] m_dm [64];
  logic [31:0] m_rf [32];
  logic [31:0] m_pc;
  logic [31:0] e_pc, e_wd, e_sa, e_sd;
  logic [4:0]  e_wa;
  logic        e_we, e_st;
  string       tag;

  function automatic logic [31:0] rop(int s, int t, int d, logic [5:0] fn);
    return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, fn};
  endfunction
  function automatic logic [31:0] iop(logic [5:0] op, int s, int t, int imm);
    return {op, 5'(s), 5'(t), 16'(imm)};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic load(bit to_dm, int idx, logic [31:0] val);
    @(negedge clk);
    ld_we = 1'b1; ld_dmem = to_dm; ld_addr = AW'(idx); ld_data = val;
    if (to_dm) m_dm[idx] = val; else m_im[idx] = val;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic model_step();
    logic [31:0] ins, a, b, sx, p4, adr;
    logic [5:0] op, fn;
    int s, t, d;
    ins = m_im[m_pc[7:2]];
    op = ins[31:26]; fn = ins[5:0];
    s = ins[25:21]; t = ins[20:16]; d = ins[15:11];
    a = (s == 0) ? 32'd0 : m_rf[s];
    b = (t == 0) ? 32'd0 : m_rf[t];
    sx = {{16{ins[15]}}, ins[15:0]};
    p4 = m_pc + 4;
    e_pc = p4; e_we = 0; e_st = 0; e_wa = 0; e_wd = 0; e_sa = 0; e_sd = 0;
    tag = "R8";
    if (op == 6'h00 && (fn == 6'h20 || fn == 6'h22 || fn == 6'h24 || fn == 6'h25 || fn == 6'h2A)) begin
      e_we = 1; e_wa = 5'(d);
      case (fn)
        6'h20: e_wd = a + b;
        6'h22: e_wd = a - b;
        6'h24: e_wd = a & b;
        6'h25: e_wd = a | b;
        default: e_wd = (signed'(a) < signed'(b)) ? 32'd1 : 32'd0;
      endcase
      tag = (fn == 6'h2A) ? "R3" : "R2";
      if (d == 0 || s == 0) tag = "R4";
    end else if (op == 6'h23) begin
      adr = a + sx;
      e_we = 1; e_wa = 5'(t); e_wd = m_dm[adr[7:2]]; tag = "R9";
    end else if (op == 6'h2B) begin
      adr = a + sx;
      e_st = 1; e_sa = adr; e_sd = b; m_dm[adr[7:2]] = b; tag = "R5";
    end else if (op == 6'h04) begin
      if (a == b) e_pc = p4 + (sx << 2);
      tag = "R6";
    end else if (op == 6'h02) begin
      e_pc = {p4[31:28], ins[25:0], 2'b00};
      tag = "R7";
    end
    if (e_we && e_wa != 0) m_rf[e_wa] = e_wd;
    m_pc = e_pc;
  endtask

  initial begin : watchdog
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin m_im[i] = 32'hFC00_0000; m_dm[i] = 0; end
    for (int i = 0; i < 32; i++) m_rf[i] = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(pc_q == 0, "R1", "pc", pc_q, 0);
    chk(rf_we_q == 0, "R1", "rf_we", 32'(rf_we_q), 0);
    chk(st_q == 0, "R1", "st", 32'(st_q), 0);

    // R9: preload data words
    load(1, 0, 32'd5);
    load(1, 1, 32'd7);
    load(1, 2, 32'hFFFF_FFFD);
    load(1, 3, 32'd7);
    for (int i = 4; i < 8; i++) load(1, i, 32'd0);
    // program
    load(0, 0,  iop(6'h23, 0, 1, 0));
    load(0, 1,  iop(6'h23, 0, 2, 4));
    load(0, 2,  iop(6'h23, 0, 3, 8));
    load(0, 3,  rop(1, 2, 4, 6'h20));
    load(0, 4,  rop(1, 2, 5, 6'h22));
    load(0, 5,  rop(1, 2, 6, 6'h24));
    load(0, 6,  rop(1, 2, 7, 6'h25));
    load(0, 7,  rop(3, 1, 8, 6'h2A));
    load(0, 8,  rop(1, 3, 9, 6'h2A));
    load(0, 9,  rop(1, 2, 0, 6'h20));
    load(0, 10, rop(0, 1, 10, 6'h20));
    load(0, 11, iop(6'h2B, 0, 4, 16));
    load(0, 12, iop(6'h23, 0, 11, 16));
    load(0, 13, iop(6'h04, 1, 2, 5));
    load(0, 14, iop(6'h04, 2, 2, 2));
    load(0, 15, rop(1, 1, 12, 6'h20));
    load(0, 16, rop(1, 1, 12, 6'h20));
    load(0, 17, iop(6'h2B, 11, 5, -4));
    load(0, 18, iop(6'h23, 0, 13, 8));
    load(0, 19, 32'hFC22_0000);
    load(0, 20, {6'h02, 26'd23});
    load(0, 21, rop(1, 1, 14, 6'h20));
    load(0, 22, rop(1, 1, 14, 6'h20));
    load(0, 23, iop(6'h04, 0, 0, -1));

    @(negedge clk);
    rst = 1'b0;
    m_pc = 0;
    for (int cyc = 0; cyc < 40; cyc++) begin
      model_step();
      @(negedge clk);
      // R10: one instruction per clock, trace aligned with new PC
      chk(pc_q == e_pc, tag, "pc (R10)", pc_q, e_pc);
      chk(rf_we_q == e_we, tag, "rf_we", 32'(rf_we_q), 32'(e_we));
      if (e_we) begin
        chk(rf_waddr_q == e_wa, tag, "rf_waddr", 32'(rf_waddr_q), 32'(e_wa));
        chk(rf_wdata_q == e_wd, tag, "rf_wdata", rf_wdata_q, e_wd);
      end
      chk(st_q == e_st, tag, "st", 32'(st_q), 32'(e_st));
      if (e_st) begin
        chk(st_addr_q == e_sa, tag, "st_addr", st_addr_q, e_sa);
        chk(st_data_q == e_sd, tag, "st_data", st_data_q, e_sd);
      end
    end

    // R1: reset again mid-run
    rst = 1'b1;
    @(negedge clk);
    chk(pc_q == 0, "R1", "pc after reset", pc_q, 0);
    chk(rf_we_q == 0 && st_q == 0, "R1", "trace after reset", {rf_we_q, st_q}, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule